// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is the front end of a storage DMA channel. Memory holds a table of 8-byte region descriptors. Each descriptor names a segment of memory by base address and byte count, and one flag marks the final entry. A command selects a table base and a transfer direction. The block then serves transfer requests. Each request asks for a number of bytes. The walker fetches descriptors over a 32-bit read port with a valid/ready handshake. It then hands out address/length segment requests to a data mover until the requested byte count is covered or the table runs out.

Segment state left over when a request finishes is kept for the next request of the same command. A new command discards it. A walk also stops once the descriptor pointer has moved a whole page past the table base, whether or not any entry carries the final flag. This guards against a table that has no terminator.

Top module: `sg_table_walker`

## Requirements
- R1: After reset these outputs are all low: `busy_o`, `done_o`, `table_end_o`, `rd_valid_o` and `seg_valid_o`.
- R2: A descriptor fetch reads the 32-bit word at the descriptor pointer and then the word at pointer+4. The first word is the segment address and the second holds the count and flags. `rd_valid_o` and `rd_addr_o` hold until `rd_ready_i`. After each fetch the pointer advances by 8.
- R3: The segment byte count is bits 15:0 of the second word with bit 0 forced to 0. Bits 30:16 have no effect.
- R4: A decoded count of zero means 65536 bytes.
- R5: Bit 31 of the second word marks the final entry. When that segment is used up and bytes are still wanted, the request ends with `table_end_o`=1 and no further fetch.
- R6: When a segment is used up and the descriptor pointer is PAGE_BYTES or more past the table base, the request ends with `table_end_o`=1 and no fetch.
- R7: Each segment request carries the smaller of the bytes still wanted and the bytes left in the current segment. Successive segments from one descriptor are contiguous. A segment length is never 0 and never above 65536.
- R8: When the wanted count is met, the request ends with `table_end_o`=0. The unused part of the segment is served first by the next request.
- R9: `start_i` while idle loads the table base and direction and discards all segment state. The next request fetches from the new base.
- R10: `seg_dir_o` equals the `dir_i` of the current command and does not change while busy.
- R11: `seg_valid_o`, `seg_addr_o` and `seg_len_o` hold until `seg_ready_i`.
- R12: A request for zero bytes completes with `table_end_o`=0. It issues no fetch and no segment.
- R13: `done_o` is a one-cycle pulse. `busy_o` is low while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new command (sampled while idle) |
| base_i | input | AW | Descriptor table base address |
| dir_i | input | 1 | Transfer direction for the command |
| req_i | input | 1 | Transfer request (sampled while idle, when start_i is low) |
| req_bytes_i | input | CW | Bytes wanted by the request |
| busy_o | output | 1 | A request is being served |
| done_o | output | 1 | One-cycle request-finished pulse |
| table_end_o | output | 1 | Result of the last request: 1 = table ran out |
| rd_valid_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | AW | Descriptor word address |
| rd_ready_i | input | 1 | Read request accepted |
| rdata_valid_i | input | 1 | Read data returned |
| rdata_i | input | 32 | Read data word |
| seg_valid_o | output | 1 | Segment request valid |
| seg_addr_o | output | 32 | Segment memory address |
| seg_len_o | output | 17 | Segment byte count |
| seg_dir_o | output | 1 | Segment direction |
| seg_ready_i | input | 1 | Segment request accepted |

## Verification
The assertions rely on the memory side raising `rd_ready_i` only while a read is pending. They also assume it returns exactly one `rdata_valid_i` beat per accepted read, strictly after acceptance. Likewise, `start_i` and `req_i` are assumed to arrive only while the block is idle. The bench responder keeps to these rules by construction: it accepts a read only while `rd_valid_o` is high, and it answers each read once, two cycles after acceptance. It also stalls every other segment handshake. The main sequence issues commands and requests only after `done_o` or reset, so they never overlap a walk.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;
  localparam int SEG_LEN_W   = 17;
  localparam int DESC_STRIDE = 8;
  localparam int WORD_BYTES  = 4;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_CHECK,
    WS_RD_A,
    WS_WT_A,
    WS_RD_B,
    WS_WT_B,
    WS_SEG
  } walk_state_e;
endpackage

// File: rtl/sg_desc_decode.sv
module sg_desc_decode #(
  parameter int LW = 17
) (
  input  logic        final_bit_i,
  input  logic [14:0] cnt_hi_i,
  output logic [LW-1:0] len_o,
  output logic        last_o
);
  logic [15:0] even_cnt;

  assign even_cnt = {cnt_hi_i, 1'b0};
  assign len_o    = (even_cnt == 16'd0) ? LW'(1 << 16) : LW'(even_cnt);
  assign last_o   = final_bit_i;
endmodule

// File: rtl/sg_step_min.sv
module sg_step_min #(
  parameter int CW = 24,
  parameter int LW = 17
) (
  input  logic [CW-1:0] want_i,
  input  logic [LW-1:0] rem_i,
  output logic [LW-1:0] step_o
);
  generate
    if (CW >= LW) begin : g_wide
      logic [CW-1:0] rem_x;
      assign rem_x  = CW'(rem_i);
      assign step_o = (want_i < rem_x) ? want_i[LW-1:0] : rem_i;
    end else begin : g_narrow
      logic [LW-1:0] want_x;
      assign want_x = LW'(want_i);
      assign step_o = (want_x < rem_i) ? want_x : rem_i;
    end
  endgenerate
endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker #(
  parameter int AW         = 32,
  parameter int CW         = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic [AW-1:0]                     base_i,
  input  logic                              dir_i,
  input  logic                              req_i,
  input  logic [CW-1:0]                     req_bytes_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic                              table_end_o,
  output logic                              rd_valid_o,
  output logic [AW-1:0]                     rd_addr_o,
  input  logic                              rd_ready_i,
  input  logic                              rdata_valid_i,
  input  logic [31:0]                       rdata_i,
  output logic                              seg_valid_o,
  output logic [31:0]                       seg_addr_o,
  output logic [sg_walk_pkg::SEG_LEN_W-1:0] seg_len_o,
  output logic                              seg_dir_o,
  input  logic                              seg_ready_i
);
  import sg_walk_pkg::*;

  localparam int LW = SEG_LEN_W;
  localparam logic [AW-1:0] GUARD  = AW'(PAGE_BYTES);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);
  localparam logic [AW-1:0] WSTEP  = AW'(WORD_BYTES);

  walk_state_e   state;
  logic [AW-1:0] base_r;
  logic [AW-1:0] cur_ptr;
  logic [31:0]   word0_r;
  logic [31:0]   seg_addr_r;
  logic [LW-1:0] seg_rem;
  logic          seg_last;
  logic [CW-1:0] want;
  logic [LW-1:0] dec_len;
  logic          dec_last;
  logic [LW-1:0] step;
  logic [AW-1:0] ptr_off;

  sg_desc_decode #(.LW(LW)) u_decode (
    .final_bit_i (rdata_i[31]),
    .cnt_hi_i    (rdata_i[15:1]),
    .len_o       (dec_len),
    .last_o      (dec_last)
  );

  sg_step_min #(.CW(CW), .LW(LW)) u_step (
    .want_i (want),
    .rem_i  (seg_rem),
    .step_o (step)
  );

  assign ptr_off = cur_ptr - base_r;
  assign busy_o  = (state != WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WS_IDLE;
      base_r      <= '0;
      cur_ptr     <= '0;
      word0_r     <= '0;
      seg_addr_r  <= '0;
      seg_rem     <= '0;
      seg_last    <= 1'b0;
      want        <= '0;
      done_o      <= 1'b0;
      table_end_o <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_addr_o   <= '0;
      seg_valid_o <= 1'b0;
      seg_addr_o  <= '0;
      seg_len_o   <= '0;
      seg_dir_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        WS_IDLE: begin
          if (start_i) begin
            base_r     <= base_i;
            cur_ptr    <= base_i;
            seg_dir_o  <= dir_i;
            seg_addr_r <= '0;
            seg_rem    <= '0;
            seg_last   <= 1'b0;
          end else if (req_i) begin
            want  <= req_bytes_i;
            state <= WS_CHECK;
          end
        end
        WS_CHECK: begin
          if (want == '0) begin
            done_o      <= 1'b1;
            table_end_o <= 1'b0;
            state       <= WS_IDLE;
          end else if (seg_rem == '0) begin
            if (seg_last || (ptr_off >= GUARD)) begin
              done_o      <= 1'b1;
              table_end_o <= 1'b1;
              state       <= WS_IDLE;
            end else begin
              rd_valid_o <= 1'b1;
              rd_addr_o  <= cur_ptr;
              state      <= WS_RD_A;
            end
          end else begin
            seg_valid_o <= 1'b1;
            seg_addr_o  <= seg_addr_r;
            seg_len_o   <= step;
            state       <= WS_SEG;
          end
        end
        WS_RD_A: begin
          if (rd_ready_i) begin
            rd_valid_o <= 1'b0;
            state      <= WS_WT_A;
          end
        end
        WS_WT_A: begin
          if (rdata_valid_i) begin
            word0_r    <= rdata_i;
            rd_valid_o <= 1'b1;
            rd_addr_o  <= cur_ptr + WSTEP;
            state      <= WS_RD_B;
          end
        end
        WS_RD_B: begin
          if (rd_ready_i) begin
            rd_valid_o <= 1'b0;
            state      <= WS_WT_B;
          end
        end
        WS_WT_B: begin
          if (rdata_valid_i) begin
            seg_addr_r <= word0_r;
            seg_rem    <= dec_len;
            seg_last   <= dec_last;
            cur_ptr    <= cur_ptr + STRIDE;
            state      <= WS_CHECK;
          end
        end
        WS_SEG: begin
          if (seg_ready_i) begin
            seg_valid_o <= 1'b0;
            seg_addr_r  <= seg_addr_r + 32'(seg_len_o);
            seg_rem     <= seg_rem - seg_len_o;
            want        <= want - CW'(seg_len_o);
            state       <= WS_CHECK;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_table_walker_chk.sv
module sg_table_walker_chk #(
  parameter int AW = 32,
  parameter int LW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic          rd_valid_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ready_i,
  input logic          seg_valid_o,
  input logic [31:0]   seg_addr_o,
  input logic [LW-1:0] seg_len_o,
  input logic          seg_dir_o,
  input logic          seg_ready_i
);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

  // R11
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seg_valid_o && !seg_ready_i) |=>
      (seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o)));

  // R7
  seg_len_range_chk: assert property (@(posedge clk) disable iff (rst)
    seg_valid_o |-> (seg_len_o != '0 && seg_len_o <= LW'(1 << 16)));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R10
  dir_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(seg_dir_o));

  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid_o && seg_valid_o));
endmodule

bind sg_table_walker sg_table_walker_chk #(.AW(AW), .LW(sg_walk_pkg::SEG_LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_valid_o  (rd_valid_o),
  .rd_addr_o   (rd_addr_o),
  .rd_ready_i  (rd_ready_i),
  .seg_valid_o (seg_valid_o),
  .seg_addr_o  (seg_addr_o),
  .seg_len_o   (seg_len_o),
  .seg_dir_o   (seg_dir_o),
  .seg_ready_i (seg_ready_i)
);

// File: tb/sg_table_walker_test.sv
`timescale 1ns/1ps
module sg_table_walker_test;
  localparam int AW = 32;
  localparam int CW = 24;
  localparam int PAGE = 64;
  localparam int MAXS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic dir_i = 1'b0;
  logic req_i = 1'b0;
  logic [CW-1:0] req_bytes_i = '0;
  logic busy_o, done_o, table_end_o, rd_valid_o, seg_valid_o, seg_dir_o;
  logic [AW-1:0] rd_addr_o;
  logic rd_ready_i = 1'b0;
  logic rdata_valid_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic [31:0] seg_addr_o;
  logic [16:0] seg_len_o;
  logic seg_ready_i = 1'b0;

  always #2.5 clk = ~clk;

  sg_table_walker #(.AW(AW), .CW(CW), .PAGE_BYTES(PAGE)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .dir_i(dir_i),
    .req_i(req_i), .req_bytes_i(req_bytes_i), .busy_o(busy_o), .done_o(done_o),
    .table_end_o(table_end_o), .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
    .rd_ready_i(rd_ready_i), .rdata_valid_i(rdata_valid_i), .rdata_i(rdata_i),
    .seg_valid_o(seg_valid_o), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
    .seg_dir_o(seg_dir_o), .seg_ready_i(seg_ready_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mem [0:63];

  int rd_cnt = 0;
  logic pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic stall = 1'b0;
  int got_n = 0;
  logic [31:0] got_addr [0:MAXS-1];
  int got_len [0:MAXS-1];
  logic got_dir [0:MAXS-1];

  logic [31:0] m_base, m_ptr, m_saddr;
  int m_rem;
  logic m_last;
  logic m_dir;
  int exp_n, exp_reads;
  logic exp_end;
  logic [31:0] exp_addr [0:MAXS-1];
  int exp_len [0:MAXS-1];

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory read responder
  initial begin
    forever begin
      @(negedge clk);
      rdata_valid_i = 1'b0;
      if (pend) begin
        rdata_valid_i = 1'b1;
        rdata_i = mem[paddr[7:2]];
        pend = 1'b0;
      end
      if (rd_ready_i) begin
        rd_ready_i = 1'b0;
        pend = 1'b1;
      end else if (rd_valid_o) begin
        rd_ready_i = 1'b1;
        paddr = rd_addr_o;
        rd_cnt++;
      end
    end
  end

  // segment sink, stalls every other opportunity
  initial begin
    forever begin
      @(negedge clk);
      if (seg_ready_i) begin
        seg_ready_i = 1'b0;
      end else if (seg_valid_o) begin
        if (stall) begin
          seg_ready_i = 1'b1;
          if (got_n < MAXS) begin
            got_addr[got_n] = seg_addr_o;
            got_len[got_n] = int'(seg_len_o);
            got_dir[got_n] = seg_dir_o;
          end
          got_n++;
        end
        stall = ~stall;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic put_desc(input int byte_addr, input logic [31:0] a, input logic [31:0] ctl);
    mem[byte_addr / 4] = a;
    mem[byte_addr / 4 + 1] = ctl;
  endtask

  task automatic cmd(input logic [31:0] base, input logic dir);
    @(negedge clk);
    start_i = 1'b1; base_i = base; dir_i = dir;
    @(negedge clk);
    start_i = 1'b0;
    m_base = base; m_ptr = base; m_saddr = '0; m_rem = 0; m_last = 1'b0; m_dir = dir;
  endtask

  task automatic model(input int bytes);
    int want;
    bit stop;
    logic [31:0] w1;
    int l;
    want = bytes; exp_n = 0; exp_reads = 0; exp_end = 1'b0; stop = 0;
    while (!stop) begin
      if (want == 0) begin
        stop = 1;
      end else if (m_rem == 0 && (m_last || (m_ptr - m_base) >= PAGE)) begin
        exp_end = 1'b1; stop = 1;
      end else begin
        if (m_rem == 0) begin
          m_saddr = mem[m_ptr[7:2]];
          w1 = mem[m_ptr[7:2] + 6'd1];
          exp_reads += 2;
          m_rem = int'(w1[15:0]) & 32'hfffe;
          if (m_rem == 0) m_rem = 65536;
          m_last = w1[31];
          m_ptr += 8;
        end
        l = (want < m_rem) ? want : m_rem;
        if (exp_n < MAXS) begin
          exp_addr[exp_n] = m_saddr;
          exp_len[exp_n] = l;
        end
        exp_n++;
        m_saddr += 32'(l);
        m_rem -= l;
        want -= l;
      end
    end
  endtask

  task automatic run_req(input int bytes, input string req);
    int r0;
    model(bytes);
    got_n = 0;
    r0 = rd_cnt;
    @(negedge clk);
    req_i = 1'b1; req_bytes_i = CW'(bytes);
    @(negedge clk);
    req_i = 1'b0;
    while (!done_o) @(negedge clk);
    check(busy_o == 1'b0, {req, " R13 busy low at done"}, busy_o, 0);
    check(table_end_o == exp_end, {req, " R8 result flag"}, table_end_o, exp_end);
    check(got_n == exp_n, {req, " R7 segment count"}, got_n, exp_n);
    check(rd_cnt - r0 == exp_reads, {req, " R2 descriptor reads"}, rd_cnt - r0, exp_reads);
    for (int i = 0; i < exp_n && i < got_n && i < MAXS; i++) begin
      check(got_addr[i] == exp_addr[i], {req, " R7 segment address"}, got_addr[i], exp_addr[i]);
      check(got_len[i] == exp_len[i], {req, " R7 segment length"}, got_len[i], exp_len[i]);
      check(got_dir[i] == m_dir, {req, " R10 direction"}, got_dir[i], m_dir);
    end
    @(negedge clk);
    check(done_o == 1'b0, {req, " R13 done one cycle"}, done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    // table A at 0x00: odd count, zero count with junk high bits, final
    put_desc(8'h00, 32'h1000_0000, 32'h0000_0007);
    put_desc(8'h08, 32'h2000_0000, 32'h7abc_0000);
    put_desc(8'h10, 32'h3000_0000, 32'h8000_0010);
    // table B at 0x40: eight 4-byte entries, no final flag
    for (int i = 0; i < 8; i++) put_desc(8'h40 + i * 8, 32'h4000_0000 + i * 32'h100, 32'h0055_0004);
    // table C at 0x80: raw count 1, raw 0xffff junk, final with odd raw
    put_desc(8'h80, 32'h5000_0000, 32'h0000_0001);
    put_desc(8'h88, 32'h6000_0000, 32'h1234_ffff);
    put_desc(8'h90, 32'h7000_0001, 32'h8000_0003);

    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !table_end_o && !rd_valid_o && !seg_valid_o, "R1 held in reset",
          {busy_o, done_o, table_end_o, rd_valid_o, seg_valid_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && !table_end_o && !rd_valid_o && !seg_valid_o, "R1 after reset",
          {busy_o, done_o, table_end_o, rd_valid_o, seg_valid_o}, 0);

    // R3 R4 R5 R8: sweep of single requests on table A, fresh command each time
    for (int k = 0; k < 10; k++) begin
      int sizes [10] = '{1, 5, 6, 7, 100, 65542, 65557, 65558, 65559, 70000};
      cmd(32'h00, k[0]);
      run_req(sizes[k], "R4 sweep A");
    end
    // R8: continuation across requests keeps leftover segment
    cmd(32'h00, 1'b1);
    run_req(3, "R8 cont");
    run_req(3, "R8 cont");
    run_req(4, "R8 cont");
    run_req(65536, "R8 cont");
    run_req(50, "R5 cont");
    run_req(1, "R5 after end");
    // R12: zero-byte request
    cmd(32'h00, 1'b0);
    run_req(0, "R12 zero");
    run_req(2, "R12 then fetch");
    // R6: page guard with no final flag
    for (int w = 28; w <= 36; w += 4) begin
      cmd(32'h40, 1'b0);
      run_req(w, "R6 guard");
    end
    cmd(32'h40, 1'b1);
    run_req(32, "R6 exact");
    run_req(1, "R6 guard only");
    // R3 R4: table C odd counts
    for (int w = 65534; w <= 131080; w += 32767) begin
      cmd(32'h80, 1'b1);
      run_req(w, "R3 table C");
    end
    // R9: new command discards leftover
    cmd(32'h00, 1'b0);
    run_req(3, "R9 partial");
    cmd(32'h80, 1'b1);
    run_req(2, "R9 new base");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule